// File: doc/BRIEF.md
# Dual-Slot Frame Transmit Buffer

This block is the transmit half of a small memory-mapped Ethernet MAC. Software sees two frame slots, called ping and pong, on a 32-bit register bus. Each slot holds frame bytes as little-endian 32-bit words, plus a byte-count register and a control/status register. Software fills a slot, writes its byte count and sets the busy bit. The block then sends that slot's bytes on a byte-wide valid/ready stream, marks the last byte, and clears busy when the frame is done.

Each slot can also carry a second command. It loads the 48-bit station address from the first six bytes of the slot instead of sending them. The result appears on a port for the receive address filter. When both slots are armed, they go out in the order they were armed. Writing zero to a slot's status register cancels that slot. A build parameter leaves out the pong slot entirely.

Top module: `tx_pingpong`

## Requirements
- R1: After reset, both status registers and both byte-count registers read 0, `tx_valid` and `tx_irq` are low, and `station_mac` is 0.
- R2: A frame's bytes leave in buffer order, least-significant byte of each 32-bit word first. Byte k of a slot is bits [8*(k%4)+7 : 8*(k%4)] of the word at byte offset 4*(k/4) from the slot base (ping base 0x000, pong base 0x800). While `tx_ready` is low, `tx_valid` and `tx_data` hold.
- R3: `tx_last` is high on the byte whose index equals the byte count minus one, and on no other byte.
- R4: Status bit 0 (busy) of the status register (slot base + 0x7FC) starts a transfer. The block clears it once the slot has been consumed. A byte count of 0 (slot base + 0x7F4) clears busy without emitting any byte.
- R5: When busy is cleared by the block while status bit 3 (interrupt enable) is set, `tx_irq` pulses high. No pulse occurs when bit 3 is clear.
- R6: Writing status with bit 1 and bit 0 both set loads `station_mac` from the first six slot bytes, with byte 0 in bits [47:40] and byte 5 in bits [7:0]. No byte is sent, and both bits then read 0.
- R7: When both slots are busy, the one armed first is sent completely before the other starts, whichever slot that is.
- R8: Writing 0 to the status register of the slot being sent stops it. `tx_valid` falls, no further byte of that frame appears, and status reads 0.
- R9: Only bits [15:0] of a byte-count write are kept. Bits [31:16] read back 0 and do not affect the number of bytes sent.
- R10: With `HAS_PONG` = 0, pong registers read 0 and writes to the pong slot start nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register/buffer write strobe |
| bus_rd | input | 1 | Register read strobe; data returned the next cycle |
| bus_addr | input | SLOT_AW+1 | Byte address; top bit selects pong |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| tx_valid | output | 1 | Output byte valid |
| tx_ready | input | 1 | Sink accepts byte |
| tx_data | output | 8 | Output byte |
| tx_last | output | 1 | Final byte of frame |
| tx_irq | output | 1 | One-cycle transmit-done pulse |
| station_mac | output | 48 | Programmed station address |

## Verification
The stall-hold property assumes that software does not write any register while the sink is stalling a byte; only a cancel may drop `tx_valid`. The bench meets this by issuing cancels only through status writes, which the property excludes. All other writes happen while the slot being written is idle. The pong-silence property assumes that the read port returns zero for an absent slot, and the bench checks this with a second instance built without pong. Frame data follows an arithmetic byte pattern, so each received byte can be recomputed from its index and a seed.

// File: rtl/tx_pingpong.sv
module tx_pingpong #(
  parameter bit HAS_PONG = 1'b1,
  parameter int SLOT_AW  = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [SLOT_AW:0] bus_addr,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  output logic             tx_valid,
  input  logic             tx_ready,
  output logic [7:0]       tx_data,
  output logic             tx_last,
  output logic             tx_irq,
  output logic [47:0]      station_mac
);
  localparam int WI = SLOT_AW - 2;
  localparam int SLOT_WORDS = 2 ** WI;
  localparam logic [SLOT_AW-1:0] LEN_OFS  = SLOT_AW'(2 ** SLOT_AW - 12);
  localparam logic [SLOT_AW-1:0] STAT_OFS = SLOT_AW'(2 ** SLOT_AW - 4);

  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_SEND, S_PROG} state_t;

  logic [31:0]        mem [2*SLOT_WORDS];
  logic [15:0]        len_q [2];
  logic [2:0]         st_q  [2];
  state_t             state;
  logic               act, pref, is_prog;
  logic [WI-1:0]      widx;
  logic [1:0]         bsel;
  logic [15:0]        bcnt;
  logic [31:0]        word_q;

  logic               sel_b, acc_ok, wr_data, wr_len, wr_st;
  logic [SLOT_AW-1:0] ofs;
  logic               any, pick, fin, fin_buf, abort_act;

  assign sel_b   = bus_addr[SLOT_AW];
  assign ofs     = bus_addr[SLOT_AW-1:0];
  assign acc_ok  = !sel_b || HAS_PONG;
  assign wr_data = bus_wr && acc_ok && (ofs < LEN_OFS);
  assign wr_len  = bus_wr && acc_ok && (ofs == LEN_OFS);
  assign wr_st   = bus_wr && acc_ok && (ofs == STAT_OFS);

  assign any  = st_q[0][0] || st_q[1][0];
  assign pick = (st_q[0][0] && st_q[1][0]) ? pref : st_q[1][0];

  assign fin_buf = (state == S_IDLE) ? pick : act;
  assign fin = ((state == S_IDLE) && any && !st_q[pick][1] && (len_q[pick] == 16'd0))
            || ((state == S_SEND) && tx_ready && (bcnt == len_q[act] - 16'd1))
            || ((state == S_PROG) && (widx != '0));
  assign abort_act = wr_st && (sel_b == act) && !bus_wdata[0] && (state != S_IDLE);

  assign tx_valid = (state == S_SEND);
  assign tx_data  = word_q[8*bsel +: 8];
  assign tx_last  = tx_valid && (bcnt == len_q[act] - 16'd1);

  always_ff @(posedge clk) begin
    if (wr_data) mem[{sel_b, ofs[SLOT_AW-1:2]}] <= bus_wdata;
    if (state == S_FETCH) word_q <= mem[{act, widx}];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q[0]   <= '0;
      st_q[1]   <= '0;
      len_q[0]  <= '0;
      len_q[1]  <= '0;
      pref      <= 1'b0;
      tx_irq    <= 1'b0;
      bus_rdata <= '0;
    end else begin
      tx_irq <= fin && st_q[fin_buf][2];
      for (int b = 0; b < 2; b++) begin
        if (wr_st && (sel_b == 1'(b)))
          st_q[b] <= {bus_wdata[3], bus_wdata[1], bus_wdata[0]};
        else if (fin && (fin_buf == 1'(b)))
          st_q[b][1:0] <= 2'b00;
        if (wr_len && (sel_b == 1'(b)))
          len_q[b] <= bus_wdata[15:0];
      end
      if (wr_st && bus_wdata[0] && !st_q[sel_b][0] && !st_q[!sel_b][0])
        pref <= sel_b;
      if (bus_rd) begin
        if (!acc_ok)                 bus_rdata <= '0;
        else if (ofs == LEN_OFS)     bus_rdata <= {16'd0, len_q[sel_b]};
        else if (ofs == STAT_OFS)    bus_rdata <= {28'd0, st_q[sel_b][2], 1'b0, st_q[sel_b][1:0]};
        else                         bus_rdata <= '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      act         <= 1'b0;
      is_prog     <= 1'b0;
      widx        <= '0;
      bsel        <= '0;
      bcnt        <= '0;
      station_mac <= '0;
    end else if (abort_act) begin
      state <= S_IDLE;
    end else begin
      case (state)
        S_IDLE: if (any) begin
          act     <= pick;
          is_prog <= st_q[pick][1];
          widx    <= '0;
          bsel    <= '0;
          bcnt    <= '0;
          if (!fin) state <= S_FETCH;
        end
        S_FETCH: state <= is_prog ? S_PROG : S_SEND;
        S_SEND: if (tx_ready) begin
          bcnt <= bcnt + 16'd1;
          if (fin) state <= S_IDLE;
          else if (bsel == 2'd3) begin
            bsel  <= '0;
            widx  <= widx + 1'b1;
            state <= S_FETCH;
          end else bsel <= bsel + 2'd1;
        end
        S_PROG: begin
          if (widx == '0) begin
            station_mac[47:16] <= {word_q[7:0], word_q[15:8], word_q[23:16], word_q[31:24]};
            widx  <= widx + 1'b1;
            state <= S_FETCH;
          end else begin
            station_mac[15:0] <= {word_q[7:0], word_q[15:8]};
            state <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tx_pingpong_chk.sv
module tx_pingpong_chk #(
  parameter bit HAS_PONG = 1'b1,
  parameter int SLOT_AW  = 11
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_wr,
  input logic             bus_rd,
  input logic [SLOT_AW:0] bus_addr,
  input logic [31:0]      bus_rdata,
  input logic             tx_valid,
  input logic             tx_ready,
  input logic [7:0]       tx_data,
  input logic             tx_last,
  input logic             tx_irq,
  input logic [47:0]      station_mac
);
  assert_last_in_frame_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_last |-> tx_valid);

  assert_stall_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready && !bus_wr |=> tx_valid && $stable(tx_data) && $stable(tx_last));

  assert_irq_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_irq |-> !tx_valid);

  assert_mac_change_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(station_mac) |-> !tx_valid);

  assert_pong_absent_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (HAS_PONG == 1'b0) && bus_rd && bus_addr[SLOT_AW] |=> bus_rdata == 32'd0);
endmodule

bind tx_pingpong tx_pingpong_chk #(.HAS_PONG(HAS_PONG), .SLOT_AW(SLOT_AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
  .bus_rdata(bus_rdata), .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
  .tx_last(tx_last), .tx_irq(tx_irq), .station_mac(station_mac));

// File: tb/tx_pingpong_test.sv
module tx_pingpong_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata, np_rdata;
  logic        tx_valid, tx_ready, tx_last, tx_irq;
  logic [7:0]  tx_data;
  logic [47:0] station_mac;
  logic        np_valid, np_last, np_irq;
  logic [7:0]  np_data;
  logic [47:0] np_mac;

  int checks = 0, fails = 0;
  int cap_n = 0, irq_n = 0, np_seen = 0, cyc = 0, all_cyc = 0;
  logic [7:0] cap_data [256];
  logic       cap_last [256];
  bit hold_low = 1'b0, rdy_mode = 1'b0;
  logic [31:0] rd_val, np_rd_val;

  always #2 clk = ~clk;

  tx_pingpong uut (.clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data), .tx_last(tx_last),
    .tx_irq(tx_irq), .station_mac(station_mac));

  tx_pingpong #(.HAS_PONG(1'b0)) uut_nopong (.clk(clk), .rst_n(rst_n), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(np_rdata),
    .tx_valid(np_valid), .tx_ready(1'b1), .tx_data(np_data), .tx_last(np_last),
    .tx_irq(np_irq), .station_mac(np_mac));

  initial tx_ready = 1'b1;

  always @(negedge clk) begin
    cyc++;
    tx_ready = hold_low ? 1'b0 : (rdy_mode ? ((cyc % 3) != 0) : 1'b1);
    if (rst_n && tx_valid && tx_ready && cap_n < 256) begin
      cap_data[cap_n] = tx_data;
      cap_last[cap_n] = tx_last;
      cap_n++;
    end
    if (rst_n && tx_irq) irq_n++;
    if (rst_n && np_valid) np_seen++;
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [11:0] a);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    rd_val = bus_rdata;
    np_rd_val = np_rdata;
  endtask

  task automatic load(input int b, input int len, input int seed);
    logic [11:0] base = b[0] ? 12'h800 : 12'h000;
    for (int w = 0; w < (len + 3) / 4; w++) begin
      logic [31:0] v = '0;
      for (int j = 0; j < 4; j++)
        if (4 * w + j < len) v[8*j +: 8] = 8'(4 * w + j + seed);
      bus_write(base + 12'(4 * w), v);
    end
    bus_write(base + 12'h7F4, 32'(len));
  endtask

  task automatic wait_idle(input int b);
    logic [11:0] base = b[0] ? 12'h800 : 12'h000;
    for (int i = 0; i < 3000; i++) begin
      bus_read(base + 12'h7FC);
      if (rd_val[0] == 1'b0) break;
    end
  endtask

  task automatic check_bytes(input int start, input int len, input int seed, input string req);
    for (int i = 0; i < len; i++) begin
      chk(cap_data[start + i] == 8'(i + seed), req, cap_data[start + i], 8'(i + seed));
      chk(cap_last[start + i] == (i == len - 1), "R3 last flag", cap_last[start + i], i == len - 1);
    end
  endtask

  always @(posedge clk) begin
    all_cyc++;
    if (all_cyc == 150000) begin
      checks++; fails++;
      $display("FAIL watchdog actual %0d expected done", all_cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!tx_valid && !tx_irq, "R1 outputs idle", {tx_valid, tx_irq}, 0);
    chk(station_mac == 48'd0, "R1 mac", station_mac, 0);
    bus_read(12'h7FC); chk(rd_val == 0, "R1 ping status", rd_val, 0);
    bus_read(12'hFFC); chk(rd_val == 0, "R1 pong status", rd_val, 0);
    bus_read(12'h7F4); chk(rd_val == 0, "R1 ping len", rd_val, 0);

    // R2 R3 R4 R5 sweep of lengths on both slots
    for (int b = 0; b < 2; b++) begin
      for (int len = 0; len < 14; len++) begin
        int seed = 16 * b + 3 * len;
        bit ie = (len % 3) == 0;
        int irq0;
        rdy_mode = len[0];
        load(b, len, seed);
        cap_n = 0;
        irq0 = irq_n;
        bus_write((b != 0 ? 12'h800 : 12'h000) + 12'h7FC, ie ? 32'h9 : 32'h1);
        wait_idle(b);
        repeat (3) @(negedge clk);
        chk(rd_val[0] == 1'b0, "R4 busy cleared", rd_val, 0);
        chk(cap_n == len, "R4 byte count", cap_n, len);
        check_bytes(0, len, seed, "R2 byte order");
        chk(irq_n - irq0 == int'(ie), "R5 irq pulses", irq_n - irq0, ie);
      end
    end
    rdy_mode = 1'b0;

    // R6 station address load on pong
    cap_n = 0;
    bus_write(12'h800, 32'h5E3C1A02);
    bus_write(12'h804, 32'h0000917F);
    bus_write(12'hFFC, 32'h3);
    wait_idle(1);
    repeat (3) @(negedge clk);
    chk(station_mac == 48'h021A3C5E7F91, "R6 mac value", station_mac, 48'h021A3C5E7F91);
    chk(cap_n == 0, "R6 no bytes sent", cap_n, 0);
    chk(rd_val[1:0] == 2'b00, "R6 status cleared", rd_val, 0);

    // R7 arming order, both directions
    for (int first = 0; first < 2; first++) begin
      hold_low = 1'b1;
      load(first, 5, 8'h40);
      load(1 - first, 6, 8'h80);
      cap_n = 0;
      bus_write(first != 0 ? 12'hFFC : 12'h7FC, 32'h1);
      bus_write(first != 0 ? 12'h7FC : 12'hFFC, 32'h1);
      repeat (10) @(negedge clk);
      chk(cap_n == 0, "R2 stall holds", cap_n, 0);
      hold_low = 1'b0;
      wait_idle(0);
      wait_idle(1);
      repeat (3) @(negedge clk);
      chk(cap_n == 11, "R7 total bytes", cap_n, 11);
      check_bytes(0, 5, 8'h40, "R7 first armed first");
      check_bytes(5, 6, 8'h80, "R7 second armed next");
    end

    // R8 cancel during send
    hold_low = 1'b1;
    load(0, 8, 8'h20);
    cap_n = 0;
    bus_write(12'h7FC, 32'h1);
    repeat (6) @(negedge clk);
    chk(tx_valid == 1'b1, "R8 frame pending", tx_valid, 1);
    bus_write(12'h7FC, 32'h0);
    repeat (2) @(negedge clk);
    chk(tx_valid == 1'b0, "R8 valid dropped", tx_valid, 0);
    hold_low = 1'b0;
    repeat (10) @(negedge clk);
    chk(cap_n == 0, "R8 no bytes after cancel", cap_n, 0);
    bus_read(12'h7FC);
    chk(rd_val == 0, "R8 status idle", rd_val, 0);

    // R9 only low half of length kept
    load(0, 3, 8'h60);
    bus_write(12'h7F4, 32'hABCD0003);
    bus_read(12'h7F4);
    chk(rd_val == 32'h3, "R9 length readback", rd_val, 3);
    cap_n = 0;
    bus_write(12'h7FC, 32'h1);
    wait_idle(0);
    repeat (3) @(negedge clk);
    chk(cap_n == 3, "R9 byte count", cap_n, 3);
    check_bytes(0, 3, 8'h60, "R9 bytes");

    // R10 absent pong slot
    np_seen = 0;
    bus_write(12'hFF4, 32'h4);
    bus_write(12'hFFC, 32'h1);
    repeat (10) @(negedge clk);
    bus_read(12'hFFC);
    chk(np_rd_val == 0, "R10 pong status reads 0", np_rd_val, 0);
    bus_read(12'hFF4);
    chk(np_rd_val == 0, "R10 pong length reads 0", np_rd_val, 0);
    chk(np_seen == 0, "R10 no output", np_seen, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule